// File: doc/BRIEF.md
# Compare-Branch Fusion Detector

This block sits in an instruction decode stage and looks at a window of `W` pre-decoded instruction descriptors each cycle (four by default). Each descriptor carries a valid bit, a two-bit instruction class, a four-bit condition code, an operating-mode bit and an opaque tag. Sometimes a flag-setting compare or test is followed at once by a conditional branch, and the branch's condition qualifies for that opcode kind. The block then marks the pair as fused, so that the pair takes a single slot through decode, execute and retire.

The block gives two outputs. The first is a per-input-slot head flag that marks where each fused pair starts. The second is a compacted micro-op stream. In that stream the absorbed branch slot and any empty input slot are removed, and the remaining entries move up to the low positions in program order. A fused entry carries the compare's tag and the branch's condition code. The outputs are registered once. A pair never spans two windows.

There is no state machine. The block is one combinational pass: pair qualification, then greedy leftmost selection, then compaction. A single output register stage follows it.

Top module: `fusion_detect`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, every output is zero.
- R2: The outputs show the window that was presented on the previous rising clock edge. A change at the inputs does not reach the outputs before the next edge.
- R3: A TEST (class 2) followed in the next slot by a conditional branch (class 3) fuses for every condition code 0 to 15.
- R4: A CMP (class 1) followed by a conditional branch fuses when the branch condition is 2, 3, 4, 5, 6 or 7 (below, not-below, equal, not-equal, below-or-equal, above), or 12, 13, 14 or 15 (signed less, greater-or-equal, less-or-equal, greater).
- R5: A CMP followed by a conditional branch with condition 0, 1, 8, 9, 10 or 11 (overflow, sign and parity, both polarities) does not fuse. Both entries then appear separately in the stream.
- R6: With the default parameters, fusion does not depend on the mode bit. Results are the same in 32-bit mode (0) and in 64-bit mode (1).
- R7: Only a valid compare or test at slot i paired with a valid branch at slot i+1 fuses. A plain instruction (class 0) in between, or an invalid partner, prevents fusion.
- R8: A compare in the last slot of a window never fuses with a branch in slot 0 of the next window, and `out_head[W-1]` is always 0.
- R9: Pairs are chosen from the lowest slot upward. A slot absorbed as the second half of a pair never starts another pair, so no two adjacent head flags are set.
- R10: The stream holds every kept entry in program order, packed into positions 0 upward. `out_uop_valid` is a contiguous run from bit 0, `out_uop_count` equals its population, a fused entry has `out_uop_fused` set, and the number of fused entries equals the number of head flags.
- R11: Invalid input slots are dropped from the stream. A kept entry carries its own tag. A fused entry carries the branch's condition code, and any other entry carries its own condition code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | W | Slot holds an instruction |
| in_cls | input | 2*W | Class per slot: 0 plain, 1 CMP, 2 TEST, 3 conditional branch |
| in_cond | input | 4*W | Condition code per slot |
| in_mode64 | input | W | 1 = 64-bit mode, 0 = 32-bit mode |
| in_tag | input | TW*W | Opaque instruction tag per slot |
| out_head | output | W | Slot i starts a fused pair with slot i+1 |
| out_uop_valid | output | W | Stream position holds an entry |
| out_uop_tag | output | TW*W | Tag of each stream entry |
| out_uop_cond | output | 4*W | Condition code of each stream entry |
| out_uop_fused | output | W | Stream entry is a fused pair |
| out_uop_count | output | CW | Number of stream entries |

## Verification
The bench walks every condition code behind both TEST and CMP, in both modes. A design with the wrong CMP table would fuse on overflow, sign or parity, or miss the signed conditions. It also places a CMP in the last slot and the branch in slot 0 of the next window, where a design that kept state across windows would report a spurious pair. Further windows check that back-to-back pairs, CMP-CMP-branch chains and invalid partners are handled. An off-by-one in selection or compaction would then leave holes in the stream, take the wrong tag or the wrong condition, or set adjacent heads. Random windows then compare the whole output against a model built from the requirements.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_CMP   = 2'd1,
        CLS_TEST  = 2'd2,
        CLS_JCC   = 2'd3
    } cls_e;

    localparam int CC_W  = 4;
    localparam int CLS_W = 2;

    // Overflow, sign and parity branches never pair with a compare.
    function automatic logic cmp_cond_ok(input logic [CC_W-1:0] cc);
        unique case (cc)
            4'h0, 4'h1, 4'h8, 4'h9, 4'hA, 4'hB: return 1'b0;
            default:                            return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fuse_pair_check.sv
module fuse_pair_check
    import fuse_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]            valid,
    input  logic [W-1:0][CLS_W-1:0] cls,
    input  logic [W-1:0][CC_W-1:0]  cond,
    input  logic [W-1:0]            mode_ok,
    output logic [W-2:0]            pair_ok
);

    generate
        for (genvar i = 0; i < W - 1; i++) begin : g_pair
            logic lead_test, lead_cmp, tail_jcc, both_live;
            assign lead_test = (cls[i] == CLS_TEST);
            assign lead_cmp  = (cls[i] == CLS_CMP);
            assign tail_jcc  = (cls[i+1] == CLS_JCC);
            assign both_live = valid[i] & valid[i+1] & mode_ok[i] & mode_ok[i+1];
            assign pair_ok[i] = both_live & tail_jcc &
                                (lead_test | (lead_cmp & cmp_cond_ok(cond[i+1])));
        end
    endgenerate

endmodule

// File: rtl/fuse_select.sv
module fuse_select #(
    parameter int W = 4
) (
    input  logic [W-2:0] pair_ok,
    output logic [W-1:0] head,
    output logic [W-1:0] absorbed
);

    always_comb begin
        head     = '0;
        absorbed = '0;
        for (int i = 0; i < W - 1; i++) begin
            if (pair_ok[i] && !absorbed[i]) begin
                head[i]       = 1'b1;
                absorbed[i+1] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fuse_compact.sv
module fuse_compact
    import fuse_pkg::*;
#(
    parameter int W  = 4,
    parameter int TW = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]           keep,
    input  logic [W-1:0]           head,
    input  logic [W-1:0][TW-1:0]   tag,
    input  logic [W-1:0][CC_W-1:0] cond,
    output logic [W-1:0]           o_valid,
    output logic [W-1:0]           o_fused,
    output logic [W-1:0][TW-1:0]   o_tag,
    output logic [W-1:0][CC_W-1:0] o_cond,
    output logic [CW-1:0]          o_count
);

    logic [W-1:0][CW-1:0] slot_pos;

    always_comb begin
        logic [CW-1:0] run;
        run = '0;
        for (int i = 0; i < W; i++) begin
            slot_pos[i] = run;
            if (keep[i]) run = run + CW'(1);
        end
        o_count = run;
    end

    always_comb begin
        o_valid = '0;
        o_fused = '0;
        o_tag   = '0;
        o_cond  = '0;
        for (int j = 0; j < W; j++) begin
            for (int i = j; i < W; i++) begin
                if (keep[i] && slot_pos[i] == CW'(j)) begin
                    o_valid[j] = 1'b1;
                    o_fused[j] = head[i];
                    o_tag[j]   = tag[i];
                    o_cond[j]  = cond[i];
                end
            end
        end
    end

endmodule

// File: rtl/fusion_detect.sv
module fusion_detect
    import fuse_pkg::*;
#(
    parameter int W          = 4,
    parameter int TW         = 8,
    parameter bit FUSE_IN_32 = 1'b1,
    parameter bit FUSE_IN_64 = 1'b1,
    localparam int CW = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      in_valid,
    input  logic [2*W-1:0]    in_cls,
    input  logic [4*W-1:0]    in_cond,
    input  logic [W-1:0]      in_mode64,
    input  logic [TW*W-1:0]   in_tag,
    output logic [W-1:0]      out_head,
    output logic [W-1:0]      out_uop_valid,
    output logic [TW*W-1:0]   out_uop_tag,
    output logic [4*W-1:0]    out_uop_cond,
    output logic [W-1:0]      out_uop_fused,
    output logic [CW-1:0]     out_uop_count
);

    logic [W-1:0][CLS_W-1:0] cls_w;
    logic [W-1:0][CC_W-1:0]  cond_w;
    logic [W-1:0][TW-1:0]    tag_w;
    logic [W-1:0]            mode_ok;
    logic [W-2:0]            pair_ok;
    logic [W-1:0]            head, absorbed, keep;
    logic [W-1:0][CC_W-1:0]  cond_sel;

    logic [W-1:0]            c_valid, c_fused;
    logic [W-1:0][TW-1:0]    c_tag;
    logic [W-1:0][CC_W-1:0]  c_cond;
    logic [CW-1:0]           c_count;

    assign cls_w  = in_cls;
    assign cond_w = in_cond;
    assign tag_w  = in_tag;

    generate
        for (genvar i = 0; i < W; i++) begin : g_slot
            assign mode_ok[i] = in_mode64[i] ? FUSE_IN_64 : FUSE_IN_32;
            assign keep[i]    = in_valid[i] & ~absorbed[i];
            if (i < W - 1) begin : g_inner
                assign cond_sel[i] = head[i] ? cond_w[i+1] : cond_w[i];
            end else begin : g_last
                assign cond_sel[i] = cond_w[i];
            end
        end
    endgenerate

    fuse_pair_check #(.W(W)) i_pair (
        .valid   (in_valid),
        .cls     (cls_w),
        .cond    (cond_w),
        .mode_ok (mode_ok),
        .pair_ok (pair_ok)
    );

    fuse_select #(.W(W)) i_select (
        .pair_ok  (pair_ok),
        .head     (head),
        .absorbed (absorbed)
    );

    fuse_compact #(.W(W), .TW(TW)) i_compact (
        .keep    (keep),
        .head    (head),
        .tag     (tag_w),
        .cond    (cond_sel),
        .o_valid (c_valid),
        .o_fused (c_fused),
        .o_tag   (c_tag),
        .o_cond  (c_cond),
        .o_count (c_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_head      <= '0;
            out_uop_valid <= '0;
            out_uop_tag   <= '0;
            out_uop_cond  <= '0;
            out_uop_fused <= '0;
            out_uop_count <= '0;
        end else begin
            out_head      <= head;
            out_uop_valid <= c_valid;
            out_uop_tag   <= c_tag;
            out_uop_cond  <= c_cond;
            out_uop_fused <= c_fused;
            out_uop_count <= c_count;
        end
    end

    // R10: stream is a contiguous run from position 0
    a_r10_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_uop_valid & (out_uop_valid + W'(1))) == '0));

    // R10: count matches the occupied positions
    a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_uop_valid) == int'(out_uop_count)));

    // R10: fused entries match the head flags
    a_r10_fused_heads: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_uop_fused) == $countones(out_head)));

    // R9: an absorbed branch never heads a pair
    a_r9_no_adjacent_heads: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_head & (out_head >> 1)) == '0));

    // R8: no pair leaves the window
    a_r8_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !out_head[W-1]);

    // R2: an empty window gives an empty stream one edge later
    a_r2_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid == '0) |=> (out_uop_valid == '0 && out_head == '0));

endmodule

// File: tb/test_fusion_detect.sv
module test_fusion_detect;

    localparam int W  = 4;
    localparam int TW = 8;
    localparam int CW = $clog2(W + 1);
    localparam time CYC = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CYC/2) clk = ~clk;

    logic [W-1:0]        d_valid;
    logic [W-1:0][1:0]   d_cls;
    logic [W-1:0][3:0]   d_cond;
    logic [W-1:0]        d_mode;
    logic [W-1:0][TW-1:0] d_tag;

    logic [W-1:0]        out_head, out_uop_valid, out_uop_fused;
    logic [W-1:0][TW-1:0] out_uop_tag;
    logic [W-1:0][3:0]   out_uop_cond;
    logic [CW-1:0]       out_uop_count;

    fusion_detect #(.W(W), .TW(TW)) i_fusion_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (d_valid),
        .in_cls        (d_cls),
        .in_cond       (d_cond),
        .in_mode64     (d_mode),
        .in_tag        (d_tag),
        .out_head      (out_head),
        .out_uop_valid (out_uop_valid),
        .out_uop_tag   (out_uop_tag),
        .out_uop_cond  (out_uop_cond),
        .out_uop_fused (out_uop_fused),
        .out_uop_count (out_uop_count)
    );

    int total = 0;
    int bad   = 0;

    logic [W-1:0]         e_head, e_valid, e_fused;
    logic [W-1:0][TW-1:0] e_tag;
    logic [W-1:0][3:0]    e_cond;
    logic [CW-1:0]        e_count;

    function automatic bit cmp_pairs(input logic [3:0] cc);
        return (cc >= 4'd2 && cc <= 4'd7) || (cc >= 4'd12);
    endfunction

    task automatic model();
        logic [W-1:0] ab;
        int p;
        e_head = '0; ab = '0;
        for (int i = 0; i < W - 1; i++) begin
            bit ok;
            ok = d_valid[i] && d_valid[i+1] && d_cls[i+1] == 2'd3 &&
                 (d_cls[i] == 2'd2 || (d_cls[i] == 2'd1 && cmp_pairs(d_cond[i+1])));
            if (ok && !ab[i]) begin e_head[i] = 1'b1; ab[i+1] = 1'b1; end
        end
        e_valid = '0; e_fused = '0; e_tag = '0; e_cond = '0; p = 0;
        for (int i = 0; i < W; i++) begin
            if (d_valid[i] && !ab[i]) begin
                e_valid[p] = 1'b1;
                e_fused[p] = e_head[i];
                e_tag[p]   = d_tag[i];
                e_cond[p]  = e_head[i] ? d_cond[i+1] : d_cond[i];
                p++;
            end
        end
        e_count = CW'(p);
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "head",  64'(out_head),      64'(e_head));
        chk(req, "valid", 64'(out_uop_valid), 64'(e_valid));
        chk(req, "fused", 64'(out_uop_fused), 64'(e_fused));
        chk(req, "tag",   64'(out_uop_tag),   64'(e_tag));
        chk(req, "cond",  64'(out_uop_cond),  64'(e_cond));
        chk(req, "count", 64'(out_uop_count), 64'(e_count));
    endtask

    // Drive a window at a falling edge; it is captured at the next rising edge
    // and sampled at the falling edge after that.
    task automatic apply();
        model();
        @(negedge clk);
    endtask

    task automatic set_slot(input int s, input logic v, input logic [1:0] c,
                            input logic [3:0] cc, input logic m);
        d_valid[s] = v; d_cls[s] = c; d_cond[s] = cc; d_mode[s] = m;
        d_tag[s] = TW'(8'h10 + s * 8'h11);
    endtask

    task automatic clear_window();
        for (int s = 0; s < W; s++) set_slot(s, 1'b1, 2'd0, 4'd0, 1'b0);
    endtask

    initial begin
        #(CYC * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        d_valid = '1; d_cls = '1; d_cond = '1; d_mode = '0; d_tag = '1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared in reset
        chk("R1", "head",  64'(out_head), 64'd0);
        chk("R1", "valid", 64'(out_uop_valid), 64'd0);
        chk("R1", "count", 64'(out_uop_count), 64'd0);
        rst_n = 1'b1;

        // R3: TEST with every condition
        for (int cc = 0; cc < 16; cc++) begin
            clear_window();
            set_slot(0, 1'b1, 2'd2, 4'd0, 1'b0);
            set_slot(1, 1'b1, 2'd3, 4'(cc), 1'b0);
            apply();
            chk("R3", "head", 64'(out_head), 64'h1);
            check_all("R3");
        end

        // R4 / R5 / R6: CMP with every condition in both modes
        for (int m = 0; m < 2; m++) begin
            for (int cc = 0; cc < 16; cc++) begin
                bit yes;
                yes = (cc >= 2 && cc <= 7) || cc >= 12;
                clear_window();
                set_slot(1, 1'b1, 2'd1, 4'd9, 1'(m));
                set_slot(2, 1'b1, 2'd3, 4'(cc), 1'(m));
                apply();
                if (yes) chk("R4", "head", 64'(out_head), 64'h2);
                else     chk("R5", "head", 64'(out_head), 64'h0);
                check_all(m == 1 ? "R6" : (yes ? "R4" : "R5"));
            end
        end

        // R7: plain instruction between compare and branch
        clear_window();
        set_slot(0, 1'b1, 2'd1, 4'd0, 1'b0);
        set_slot(2, 1'b1, 2'd3, 4'd4, 1'b0);
        apply();
        chk("R7", "head", 64'(out_head), 64'h0);
        check_all("R7");

        // R7 / R11: invalid branch partner is not fused and is dropped
        clear_window();
        set_slot(0, 1'b1, 2'd2, 4'd0, 1'b0);
        set_slot(1, 1'b0, 2'd3, 4'd4, 1'b0);
        apply();
        chk("R7", "head", 64'(out_head), 64'h0);
        chk("R11", "count", 64'(out_uop_count), 64'd3);
        check_all("R11");

        // R8: compare in last slot, branch in slot 0 of next window
        clear_window();
        set_slot(3, 1'b1, 2'd1, 4'd0, 1'b1);
        apply();
        chk("R8", "head", 64'(out_head), 64'h0);
        clear_window();
        set_slot(0, 1'b1, 2'd3, 4'd12, 1'b1);
        apply();
        chk("R8", "head", 64'(out_head), 64'h0);
        chk("R8", "fused", 64'(out_uop_fused), 64'h0);
        check_all("R8");

        // R9: two pairs back to back
        clear_window();
        set_slot(0, 1'b1, 2'd1, 4'd0, 1'b0);
        set_slot(1, 1'b1, 2'd3, 4'd4, 1'b0);
        set_slot(2, 1'b1, 2'd2, 4'd0, 1'b0);
        set_slot(3, 1'b1, 2'd3, 4'd8, 1'b0);
        apply();
        chk("R9", "head", 64'(out_head), 64'h5);
        chk("R10", "count", 64'(out_uop_count), 64'd2);
        chk("R11", "cond0", 64'(out_uop_cond[0]), 64'd4);
        check_all("R9");

        // R9: CMP CMP JCC JCC, only the second compare pairs
        clear_window();
        set_slot(0, 1'b1, 2'd1, 4'd0, 1'b0);
        set_slot(1, 1'b1, 2'd1, 4'd0, 1'b0);
        set_slot(2, 1'b1, 2'd3, 4'd15, 1'b0);
        set_slot(3, 1'b1, 2'd3, 4'd13, 1'b0);
        apply();
        chk("R9", "head", 64'(out_head), 64'h2);
        chk("R10", "tag1", 64'(out_uop_tag[1]), 64'h21);
        check_all("R10");

        // R2: outputs hold until the next rising edge
        clear_window();
        set_slot(0, 1'b1, 2'd2, 4'd0, 1'b0);
        set_slot(1, 1'b1, 2'd3, 4'd1, 1'b0);
        apply();
        chk("R2", "head before change", 64'(out_head), 64'h1);
        clear_window();
        #1;
        chk("R2", "head held", 64'(out_head), 64'h1);
        apply();
        chk("R2", "head after edge", 64'(out_head), 64'h0);

        // R10 / R11: random windows against the model
        for (int n = 0; n < 400; n++) begin
            for (int s = 0; s < W; s++) begin
                d_valid[s] = ($urandom % 8) != 0;
                d_cls[s]   = 2'($urandom);
                d_cond[s]  = 4'($urandom);
                d_mode[s]  = 1'($urandom);
                d_tag[s]   = TW'($urandom);
            end
            apply();
            check_all("R10");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule